// File: doc/BRIEF.md
# UART Transmit/Receive Buffer with Threshold Signalling

This block holds the two byte queues of one UART channel. Bytes the processor writes go into the transmit queue, where the serial side takes them. Bytes the serial side delivers go into the receive queue, together with three error bits per byte, and the processor takes them out. Outside the queues, the block drives a level request per direction. Each request goes both to the interrupt logic and to a DMA-ready pin. It asserts when the receive fill or the transmit free space reaches a trigger level.

Each direction has its own trigger level. A two-bit select picks it from a fixed set. A non-zero four-bit programmed value overrides that choice, and the level is then four times the value. When queueing is off, which is the state after reset, each direction holds one byte and both trigger levels are one. Serial shifting, baud timing, flow control and the register map belong to other blocks.

Top module: `uart_fifo_trig`

## Requirements
- R1: With queueing on, each queue holds up to 64 entries and raises its full flag at 64. A receive push to a full queue that is not popped in the same cycle is discarded and leaves the count unchanged.
- R2: Each receive entry holds the 3-bit error code from `ser_rx_err`. The code appears on `cpu_rerr` at the same time as its byte appears on `cpu_rdata`.
- R3: After reset `fifo_en` is low and each queue holds at most one byte, so a second push is discarded. In this mode both trigger levels are one: `rx_irq` asserts when the receive queue holds a byte, and `tx_irq` asserts when the transmit queue is empty.
- R4: With `rx_prog` zero and queueing on, `rx_sel` values 0, 1, 2 and 3 select receive trigger fill levels of 8, 16, 56 and 60 entries.
- R5: With `tx_prog` zero and queueing on, `tx_sel` values 0, 1, 2 and 3 select transmit trigger free-space levels of 8, 16, 32 and 56 entries.
- R6: A non-zero `rx_prog` or `tx_prog` value P overrides the select field of its direction, and the trigger level becomes 4*P.
- R7: `rx_irq` and `rx_dma_rdy` are high exactly when the receive count is at or above the receive level. `tx_irq` and `tx_dma_rdy` are high exactly when 64 minus the transmit count (1 minus the count when queueing is off) is at or above the transmit level. Both follow the count and the configuration without any added delay.
- R8: A discarded receive push sets `overrun` at the next clock edge. The flag stays set until a cycle with `ovr_rd` high and no new discard. If a discard and `ovr_rd` fall in the same cycle, the discard wins.
- R9: `rx_clr` or `tx_clr` empties its own queue at the next edge, whatever else happens in that cycle, and leaves the other queue untouched.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full leave its count unchanged. A pop of an empty queue is ignored, and so is a processor write to a full transmit queue.
- R11: Any change of `fifo_en` empties both queues at the next clock edge.
- R12: Each queue returns its bytes in the order they were written. The oldest byte is shown on the read port without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | Queueing on (64 deep) or off (one byte) |
| rx_clr | input | 1 | Empty the receive queue |
| tx_clr | input | 1 | Empty the transmit queue |
| rx_sel | input | 2 | Receive fixed trigger select |
| tx_sel | input | 2 | Transmit fixed trigger select |
| rx_prog | input | 4 | Receive programmed trigger, 0 = use select |
| tx_prog | input | 4 | Transmit programmed trigger, 0 = use select |
| cpu_wr | input | 1 | Processor write into the transmit queue |
| cpu_wdata | input | 8 | Byte to transmit |
| cpu_rd | input | 1 | Processor pop from the receive queue |
| cpu_rdata | output | 8 | Oldest received byte |
| cpu_rerr | output | 3 | Error code of the oldest received byte |
| ovr_rd | input | 1 | Processor read of the overrun flag (clears it) |
| overrun | output | 1 | Sticky receive overrun flag |
| ser_tx_pop | input | 1 | Serial side takes a transmit byte |
| ser_tx_data | output | 8 | Oldest transmit byte |
| ser_rx_push | input | 1 | Serial side delivers a byte |
| ser_rx_data | input | 8 | Delivered byte |
| ser_rx_err | input | 3 | Error code of the delivered byte |
| tx_count | output | 7 | Transmit queue fill |
| rx_count | output | 7 | Receive queue fill |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_dma_rdy | output | 1 | Receive DMA ready |
| tx_dma_rdy | output | 1 | Transmit DMA ready |

## Verification
The queues are first driven with steady fills and drains in both modes. This shows whether the one-byte limit and the 64-entry limit sit at the right count, and whether order and error codes survive the trip. At chosen fill counts the select and programmed trigger inputs are swept. This separates an off-by-one threshold or a wrong table entry from a correct one, and shows whether the programmed value takes priority. Pushes into a full queue, pushes and pops in the same cycle, clears and mode changes while data is present test the overrun flag, the count updates and the independence of the two directions. A long run of random traffic with occasional mode and configuration changes then finds interactions that the directed patterns leave out.

// File: rtl/uart_fifo_pkg.sv
// Shared constants and the fixed trigger tables of the UART buffer.
// Assumes a 64-entry depth for the table values.
package uart_fifo_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned DEF_DEPTH  = 64;
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_ERR_W  = 3;
    localparam int unsigned DEF_PROG_W = 4;
    localparam int unsigned DEF_SCALE  = 4;

    // Fixed trigger level: receive fill or transmit free space.
    function automatic int unsigned fixed_level(input logic tx_side, input logic [1:0] sel);
        int unsigned lvl;
        if (tx_side) begin
            case (sel)
                2'd0:    lvl = 8;
                2'd1:    lvl = 16;
                2'd2:    lvl = 32;
                default: lvl = 56;
            endcase
        end else begin
            case (sel)
                2'd0:    lvl = 8;
                2'd1:    lvl = 16;
                2'd2:    lvl = 56;
                default: lvl = 60;
            endcase
        end
        return lvl;
    endfunction
endpackage

// File: rtl/fifo_core.sv
// Circular queue with a fill counter and a show-ahead read port.
// When one_deep is high its capacity is one entry. clr wins over push and pop.
// A push into a full queue without a same-cycle pop is reported on drop.
module fifo_core #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             one_deep,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             drop
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Status flags and the accept decision for this cycle.
    always_comb begin
        empty   = (count == '0);
        full    = one_deep ? (count != '0) : (count == CNT_W'(DEPTH));
        pop_ok  = pop && !empty && !clr;
        push_ok = push && (!full || pop_ok) && !clr;
        drop    = push && full && !pop_ok && !clr;
        rdata   = mem[rd_ptr];
    end

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step_ptr(wr_ptr);
            if (pop_ok)  rd_ptr <= step_ptr(rd_ptr);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    p_drop_keeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> $stable(count));
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !full && !clr) |=> $stable(count));
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty && !clr) |=> empty);
endmodule

// File: rtl/trig_eval.sv
// Trigger comparison for one direction. The level comes from the fixed
// table, the programmed value (when non-zero), or is 1 with queueing off.
// FREE_SIDE compares free space (transmit); otherwise it compares the fill.
module trig_eval
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH      = 64,
    parameter int unsigned PROG_W     = 4,
    parameter int unsigned PROG_SCALE = 4,
    parameter bit          FREE_SIDE  = 1'b0,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [1:0]        sel,
    input  logic [PROG_W-1:0] prog,
    input  logic [CNT_W-1:0]  count,
    output logic              hit
);
    timeunit 1ns;
    timeprecision 100ps;

    int unsigned level, metric, cap;

    // Pick the active trigger level.
    always_comb begin
        if (!fifo_en)          level = 1;
        else if (prog != '0)   level = 32'(prog) * PROG_SCALE;
        else                   level = fixed_level(FREE_SIDE, sel);
        cap = fifo_en ? DEPTH : 1;
    end

    if (FREE_SIDE) begin : g_free
        // Free space, floored at zero during a mode change.
        always_comb metric = (32'(count) >= cap) ? 0 : cap - 32'(count);
    end else begin : g_fill
        // Fill count taken directly.
        always_comb metric = 32'(count);
    end

    // Threshold compare.
    always_comb hit = (metric >= level);

    p_level_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (level >= 1) && (level <= DEPTH));
endmodule

// File: rtl/uart_fifo_trig.sv
// One UART channel's transmit and receive queues with threshold requests.
// Assumes the processor and serial sides share clk. A change of fifo_en
// empties both queues; the sticky overrun flag clears on ovr_rd.
module uart_fifo_trig
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH      = DEF_DEPTH,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned ERR_W      = DEF_ERR_W,
    parameter int unsigned PROG_W     = DEF_PROG_W,
    parameter int unsigned PROG_SCALE = DEF_SCALE,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned RX_W  = DATA_W + ERR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              rx_clr,
    input  logic              tx_clr,
    input  logic [1:0]        rx_sel,
    input  logic [1:0]        tx_sel,
    input  logic [PROG_W-1:0] rx_prog,
    input  logic [PROG_W-1:0] tx_prog,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ERR_W-1:0]  cpu_rerr,
    input  logic              ovr_rd,
    output logic              overrun,
    input  logic              ser_tx_pop,
    output logic [DATA_W-1:0] ser_tx_data,
    input  logic              ser_rx_push,
    input  logic [DATA_W-1:0] ser_rx_data,
    input  logic [ERR_W-1:0]  ser_rx_err,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic              tx_empty,
    output logic              tx_full,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic              rx_dma_rdy,
    output logic              tx_dma_rdy
);
    timeunit 1ns;
    timeprecision 100ps;

    logic            en_q, mode_chg, rx_flush, tx_flush;
    logic            rx_drop, tx_drop, rx_hit, tx_hit;
    logic [RX_W-1:0] rx_head;

    // Remember the mode to detect a change.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en;
    end

    // Flush requests per direction.
    always_comb begin
        mode_chg = (fifo_en != en_q);
        rx_flush = rx_clr || mode_chg;
        tx_flush = tx_clr || mode_chg;
    end

    fifo_core #(.W(RX_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_flush), .one_deep(!fifo_en),
        .push(ser_rx_push), .wdata({ser_rx_err, ser_rx_data}), .pop(cpu_rd),
        .rdata(rx_head), .count(rx_count), .empty(rx_empty), .full(rx_full),
        .drop(rx_drop)
    );

    fifo_core #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_flush), .one_deep(!fifo_en),
        .push(cpu_wr), .wdata(cpu_wdata), .pop(ser_tx_pop),
        .rdata(ser_tx_data), .count(tx_count), .empty(tx_empty), .full(tx_full),
        .drop(tx_drop)
    );

    trig_eval #(.DEPTH(DEPTH), .PROG_W(PROG_W), .PROG_SCALE(PROG_SCALE),
                .FREE_SIDE(1'b0)) u_rxtrig (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .sel(rx_sel),
        .prog(rx_prog), .count(rx_count), .hit(rx_hit)
    );

    trig_eval #(.DEPTH(DEPTH), .PROG_W(PROG_W), .PROG_SCALE(PROG_SCALE),
                .FREE_SIDE(1'b1)) u_txtrig (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .sel(tx_sel),
        .prog(tx_prog), .count(tx_count), .hit(tx_hit)
    );

    // Split the receive head into byte and error code; drive the requests.
    always_comb begin
        cpu_rdata  = rx_head[DATA_W-1:0];
        cpu_rerr   = rx_head[RX_W-1:DATA_W];
        rx_irq     = rx_hit;
        rx_dma_rdy = rx_hit;
        tx_irq     = tx_hit;
        tx_dma_rdy = tx_hit;
    end

    // Sticky overrun: a discard sets it, a read clears it, a discard wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      overrun <= 1'b0;
        else if (rx_drop) overrun <= 1'b1;
        else if (ovr_rd)  overrun <= 1'b0;
    end

    p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && rx_full && !cpu_rd && !rx_clr && !mode_chg) |=> overrun);
    p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_rd) |=> overrun);
    p_one_deep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !en_q) |-> (rx_count <= CNT_W'(1)) && (tx_count <= CNT_W'(1)));
    p_rx_clr_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clr && !tx_clr && !mode_chg && !cpu_wr && !ser_tx_pop) |=> $stable(tx_count));
    p_mode_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (rx_count == '0) && (tx_count == '0));
endmodule

// File: tb/sim_uart_fifo_trig.sv
// Bench: behavioural queue model compared with the block on every clock.
module sim_uart_fifo_trig;
    timeunit 1ns;
    timeprecision 100ps;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fifo_en = 0, rx_clr = 0, tx_clr = 0, cpu_wr = 0, cpu_rd = 0;
    logic ovr_rd = 0, ser_tx_pop = 0, ser_rx_push = 0;
    logic [1:0] rx_sel = 0, tx_sel = 0;
    logic [3:0] rx_prog = 0, tx_prog = 0;
    logic [7:0] cpu_wdata = 0, ser_rx_data = 0;
    logic [2:0] ser_rx_err = 0;
    logic [7:0] cpu_rdata, ser_tx_data;
    logic [2:0] cpu_rerr;
    logic overrun, tx_empty, tx_full, rx_empty, rx_full;
    logic rx_irq, tx_irq, rx_dma_rdy, tx_dma_rdy;
    logic [6:0] tx_count, rx_count;

    int checks = 0, errors = 0;
    logic [10:0] rxq[$];
    logic [7:0]  txq[$];
    bit m_ovr = 0, m_en = 0;

    always #2.5 clk = ~clk;

    uart_fifo_trig u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_clr(rx_clr), .tx_clr(tx_clr),
        .rx_sel(rx_sel), .tx_sel(tx_sel), .rx_prog(rx_prog), .tx_prog(tx_prog),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .cpu_rerr(cpu_rerr), .ovr_rd(ovr_rd), .overrun(overrun), .ser_tx_pop(ser_tx_pop),
        .ser_tx_data(ser_tx_data), .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .ser_rx_err(ser_rx_err), .tx_count(tx_count), .rx_count(rx_count),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_dma_rdy(rx_dma_rdy), .tx_dma_rdy(tx_dma_rdy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected trigger level from the requirements (R3, R4, R5, R6).
    function automatic int exp_lvl(input bit tx, input bit en, input logic [1:0] s,
                                   input logic [3:0] p);
        if (!en) return 1;
        if (p != 0) return 4 * int'(p);
        if (tx) return (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 32 : 56;
        return (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 56 : 60;
    endfunction

    task automatic compare_all();
        int cap = fifo_en ? 64 : 1;
        int rl = exp_lvl(0, fifo_en, rx_sel, rx_prog);
        int tl = exp_lvl(1, fifo_en, tx_sel, tx_prog);
        chk("R10 rx_count", int'(rx_count), rxq.size());
        chk("R10 tx_count", int'(tx_count), txq.size());
        chk("R1 rx_full", int'(rx_full), int'(rxq.size() >= cap));
        chk("R1 tx_full", int'(tx_full), int'(txq.size() >= cap));
        chk("R10 rx_empty", int'(rx_empty), int'(rxq.size() == 0));
        chk("R10 tx_empty", int'(tx_empty), int'(txq.size() == 0));
        if (rxq.size() > 0) begin
            chk("R12 rx byte", int'(cpu_rdata), int'(rxq[0][7:0]));
            chk("R2 rx err", int'(cpu_rerr), int'(rxq[0][10:8]));
        end
        if (txq.size() > 0) chk("R12 tx byte", int'(ser_tx_data), int'(txq[0]));
        chk("R7 rx_irq", int'(rx_irq), int'(rxq.size() >= rl));
        chk("R7 rx_dma_rdy", int'(rx_dma_rdy), int'(rxq.size() >= rl));
        chk("R7 tx_irq", int'(tx_irq), int'((cap - txq.size()) >= tl));
        chk("R7 tx_dma_rdy", int'(tx_dma_rdy), int'((cap - txq.size()) >= tl));
        chk("R8 overrun", int'(overrun), int'(m_ovr));
    endtask

    task automatic model_edge();
        int cap = fifo_en ? 64 : 1;
        bit chg = (fifo_en != m_en);
        bit drop = 0;
        if (rx_clr || chg) rxq.delete();
        else begin
            bit pop = cpu_rd && rxq.size() > 0;
            drop = ser_rx_push && rxq.size() >= cap && !pop;
            if (pop) void'(rxq.pop_front());
            if (ser_rx_push && !drop) rxq.push_back({ser_rx_err, ser_rx_data});
        end
        if (drop) m_ovr = 1;
        else if (ovr_rd) m_ovr = 0;
        if (tx_clr || chg) txq.delete();
        else begin
            bit pop = ser_tx_pop && txq.size() > 0;
            bit full = txq.size() >= cap;
            if (pop) void'(txq.pop_front());
            if (cpu_wr && (!full || pop)) txq.push_back(cpu_wdata);
        end
        m_en = fifo_en;
    endtask

    // One clock: compare, apply the edge to the model, drop the strobes.
    task automatic step();
        #1 compare_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        {rx_clr, tx_clr, cpu_wr, cpu_rd, ovr_rd, ser_tx_pop, ser_rx_push} = '0;
    endtask

    // Sweep receive select and programmed values at the present fill (R4, R6).
    task automatic probe_rx();
        logic [1:0] s0 = rx_sel;
        logic [3:0] p0 = rx_prog;
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 3; k++) begin
                rx_sel = 2'(s);
                rx_prog = (k == 0) ? 4'd0 : (k == 1) ? 4'd2 : 4'd15;
                #0.1;
                chk(k == 0 ? "R4 rx fixed level" : "R6 rx prog level", int'(rx_irq),
                    int'(rxq.size() >= exp_lvl(0, fifo_en, rx_sel, rx_prog)));
            end
        end
        rx_sel = s0; rx_prog = p0;
    endtask

    // Sweep transmit select and programmed values at the present fill (R5, R6).
    task automatic probe_tx();
        logic [1:0] s0 = tx_sel;
        logic [3:0] p0 = tx_prog;
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 3; k++) begin
                tx_sel = 2'(s);
                tx_prog = (k == 0) ? 4'd0 : (k == 1) ? 4'd2 : 4'd14;
                #0.1;
                chk(k == 0 ? "R5 tx fixed level" : "R6 tx prog level", int'(tx_irq),
                    int'((64 - txq.size()) >= exp_lvl(1, fifo_en, tx_sel, tx_prog)));
            end
        end
        tx_sel = s0; tx_prog = p0;
    endtask

    initial begin
        #750000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R3: reset state, one-byte mode.
        #1;
        chk("R3 rx_count reset", int'(rx_count), 0);
        chk("R3 tx_irq reset", int'(tx_irq), 1);
        chk("R3 rx_irq reset", int'(rx_irq), 0);
        step();
        ser_rx_push = 1; ser_rx_data = 8'h11; ser_rx_err = 3'd5; step();
        chk("R3 rx_irq one byte", int'(rx_irq), 1);
        ser_rx_push = 1; ser_rx_data = 8'h22; step();
        chk("R3 second byte dropped", int'(rx_count), 1);
        chk("R8 overrun set", int'(overrun), 1);
        ovr_rd = 1; step();
        chk("R8 overrun cleared", int'(overrun), 0);
        cpu_wr = 1; cpu_wdata = 8'h33; step();
        chk("R3 tx_irq with byte", int'(tx_irq), 0);
        cpu_wr = 1; cpu_wdata = 8'h44; step();
        chk("R10 tx write to full ignored", int'(ser_tx_data), 8'h33);
        // R11: enabling flushes both queues.
        fifo_en = 1; step();
        chk("R11 rx flushed", int'(rx_count), 0);
        chk("R11 tx flushed", int'(tx_count), 0);
        // Fill the receive queue, probing trigger boundaries (R4, R6).
        rx_sel = 2'd2;
        for (int i = 0; i < 64; i++) begin
            ser_rx_push = 1; ser_rx_data = 8'(i + 1); ser_rx_err = 3'(i); step();
            if (rx_count inside {7, 8, 15, 16, 55, 56, 59, 60}) probe_rx();
        end
        chk("R1 rx full at 64", int'(rx_full), 1);
        ser_rx_push = 1; ser_rx_data = 8'hEE; step();
        chk("R1 rx push to full dropped", int'(rx_count), 64);
        chk("R8 overrun after full push", int'(overrun), 1);
        ovr_rd = 1; ser_rx_push = 1; step();
        chk("R8 discard beats clear", int'(overrun), 1);
        cpu_rd = 1; ser_rx_push = 1; ser_rx_data = 8'hAB; step();
        chk("R1 pop makes room for push", int'(rx_count), 64);
        for (int i = 0; i < 20; i++) begin cpu_rd = 1; step(); end
        cpu_rd = 1; ser_rx_push = 1; ser_rx_data = 8'h5A; ser_rx_err = 3'd7; step();
        chk("R10 push+pop keeps count", int'(rx_count), 44);
        chk("R2 err travels with byte", int'(cpu_rerr), 3'd6);
        while (rxq.size() > 0) begin cpu_rd = 1; step(); end
        cpu_rd = 1; step();
        chk("R10 pop of empty ignored", int'(rx_count), 0);
        // Transmit fill with probes (R5, R6).
        tx_sel = 2'd1;
        for (int i = 0; i < 64; i++) begin
            cpu_wr = 1; cpu_wdata = 8'(200 - i); step();
            if (tx_count inside {8, 9, 32, 33, 48, 49, 56, 57}) probe_tx();
        end
        cpu_wr = 1; cpu_wdata = 8'h01; step();
        chk("R10 tx write to full ignored", int'(tx_count), 64);
        for (int i = 0; i < 30; i++) begin ser_tx_pop = 1; step(); end
        chk("R12 tx order", int'(ser_tx_data), 200 - 30);
        // R9: clears are per direction.
        for (int i = 0; i < 3; i++) begin ser_rx_push = 1; ser_rx_data = 8'(i); step(); end
        rx_clr = 1; ser_rx_push = 1; cpu_wr = 1; step();
        chk("R9 rx cleared", int'(rx_count), 0);
        chk("R9 tx untouched", int'(tx_count), 35);
        ser_rx_push = 1; step();
        tx_clr = 1; step();
        chk("R9 tx cleared", int'(tx_count), 0);
        chk("R9 rx untouched", int'(rx_count), 1);
        cpu_wr = 1; step();
        fifo_en = 0; step();
        chk("R11 disable flushes rx", int'(rx_count), 0);
        chk("R11 disable flushes tx", int'(tx_count), 0);
        // Random traffic with occasional mode and configuration changes.
        for (int i = 0; i < 6000; i++) begin
            bit fill = ((i / 400) % 2) == 0;
            if ($urandom_range(299) == 0) fifo_en = ~fifo_en;
            if ($urandom_range(49) == 0) begin
                rx_sel = 2'($urandom); tx_sel = 2'($urandom);
                rx_prog = ($urandom_range(2) == 0) ? 4'($urandom) : 4'd0;
                tx_prog = ($urandom_range(2) == 0) ? 4'($urandom) : 4'd0;
            end
            ser_rx_push = ($urandom_range(9) < (fill ? 8 : 3));
            cpu_rd      = ($urandom_range(9) < (fill ? 3 : 8));
            cpu_wr      = ($urandom_range(9) < (fill ? 8 : 3));
            ser_tx_pop  = ($urandom_range(9) < (fill ? 3 : 8));
            rx_clr      = ($urandom_range(199) == 0);
            tx_clr      = ($urandom_range(199) == 0);
            ovr_rd      = ($urandom_range(7) == 0);
            ser_rx_data = 8'($urandom); ser_rx_err = 3'($urandom); cpu_wdata = 8'($urandom);
            step();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule